// File: doc/BRIEF.md
# Reaction Timer Controller

This block measures how quickly a person reacts. A one-cycle start pulse lights an indicator LED and starts a two-digit decimal count of elapsed time. The count unit is one hundredth of a second. When the person presses a push button, the LED goes dark and the count stops. The digits then hold the reaction time until the next reset.

The block runs from a single 102.4 kHz clock and uses no derived clocks. A power-of-two prescaler makes a one-cycle enable pulse every 1024 clock cycles, which is exactly 10 ms. The decimal counter advances only on that pulse. The active-low button passes through a two-flop synchronizer before it acts on the state bit. Each digit is also given as an active-high seven-segment pattern.

Top module: `rxn_timer`

## Requirements
- R1: While `rst_n` is low, `led` is 0 and both digits are 0. The reset acts without waiting for a clock edge.
- R2: Suppose `start_pulse` is 1 at a rising edge while `led` is 0 and no press is being seen. Then `led` is 1 after that edge.
- R3: While timing, the count rises by one every 1024 clock cycles. The first step comes at the 1024th edge after the start edge.
- R4: Each digit stays in the range 0 to 9. When the ones digit steps from 9 to 0, the tens digit goes up by one in the same cycle.
- R5: A low level on `button_n` that is sampled at edge P clears `led` at edge P+2. A count step that falls due at edge P+2 or earlier is still taken.
- R6: While `led` is 0, neither digit changes.
- R7: When the count reads 99 while timing, it holds at 99 and does not wrap.
- R8: A `start_pulse` that arrives while `led` is 1 has no effect. It does not restart the 10 ms phase and does not change the count.
- R9: Suppose `start_pulse` arrives while a synchronized press is present. Then `led` stays 0.
- R10: The segment outputs are active high, with segment a on bit 0 through segment g on bit 6. The patterns for the digits 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F (hex).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 102.4 kHz clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_pulse | input | 1 | One-cycle request to light the LED and start timing |
| button_n | input | 1 | Push button, 1 when released, 0 when pressed |
| led | output | 1 | LED drive; high while timing |
| digit_ones | output | 4 | BCD ones digit (10 ms units) |
| digit_tens | output | 4 | BCD tens digit (100 ms units) |
| seg_ones | output | 7 | Segment pattern for the ones digit |
| seg_tens | output | 7 | Segment pattern for the tens digit |

## Verification
The hardest case to reach is saturation. A count of 99 needs more than a hundred thousand cycles of uninterrupted timing. The stimulus spends one long run on it and holds the press back until well past the 99th step.

The edge cases for the stop timing are also hard to hit. These are a press whose last step lands exactly at the stop edge, and the step from 9 to 10. They are reached with directed run lengths computed from the 1024-cycle period and the two-cycle synchronizer delay. Random-length runs fill in the rest.

// File: rtl/rxn_pkg.sv
package rxn_pkg;
  localparam int unsigned DIGIT_W = 4;
  localparam int unsigned SEG_W   = 7;

  typedef logic [DIGIT_W-1:0] digit_t;
  typedef logic [SEG_W-1:0]   seg_t;

  function automatic seg_t digit_to_seg(input digit_t d);
    seg_t s;
    case (d)
      4'd0:    s = 7'h3F;
      4'd1:    s = 7'h06;
      4'd2:    s = 7'h5B;
      4'd3:    s = 7'h4F;
      4'd4:    s = 7'h66;
      4'd5:    s = 7'h6D;
      4'd6:    s = 7'h7D;
      4'd7:    s = 7'h07;
      4'd8:    s = 7'h7F;
      4'd9:    s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/rxn_sync.sv
module rxn_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], async_in};
  end

  // reset to the idle level of the button (released = 1)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/rxn_prescaler.sv
module rxn_prescaler #(
  parameter int unsigned DIV_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;

  assign tick = run && (cnt_q == {DIV_W{1'b1}});

  always_comb begin
    if (run) cnt_d = cnt_q + 1'b1;
    else     cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rxn_bcd_chain.sv
module rxn_bcd_chain
  import rxn_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          adv,
  output logic [NUM_DIGITS*DIGIT_W-1:0] digits
);
  digit_t              dig_q [NUM_DIGITS];
  digit_t              dig_d [NUM_DIGITS];
  logic [NUM_DIGITS:0] carry;
  logic [NUM_DIGITS-1:0] is_nine;
  logic                all_nine;
  logic                step;

  assign all_nine = &is_nine;
  assign step     = adv && !all_nine;
  assign carry[0] = step;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    assign is_nine[i]  = (dig_q[i] == 4'd9);
    assign carry[i+1]  = carry[i] && is_nine[i];

    always_comb begin
      if (carry[i]) dig_d[i] = is_nine[i] ? 4'd0 : dig_q[i] + 4'd1;
      else          dig_d[i] = dig_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dig_q[i] <= '0;
      else        dig_q[i] <= dig_d[i];
    end

    assign digits[i*DIGIT_W +: DIGIT_W] = dig_q[i];
  end
endmodule

// File: rtl/rxn_timer.sv
module rxn_timer
  import rxn_pkg::*;
#(
  parameter int unsigned DIV_W       = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_pulse,
  input  logic       button_n,
  output logic       led,
  output logic [3:0] digit_ones,
  output logic [3:0] digit_tens,
  output logic [6:0] seg_ones,
  output logic [6:0] seg_tens
);
  localparam int unsigned NUM_DIGITS = 2;

  logic btn_sync_n;
  logic btn_pressed;
  logic timing_q;
  logic timing_d;
  logic tick;
  logic [NUM_DIGITS*DIGIT_W-1:0] digits;

  rxn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(button_n), .sync_out(btn_sync_n)
  );

  assign btn_pressed = !btn_sync_n;

  // press has priority; a start while timing leaves the state as it is
  always_comb begin
    timing_d = timing_q;
    if (btn_pressed)      timing_d = 1'b0;
    else if (start_pulse) timing_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) timing_q <= 1'b0;
    else        timing_q <= timing_d;
  end

  rxn_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(timing_q), .tick(tick)
  );

  rxn_bcd_chain #(.NUM_DIGITS(NUM_DIGITS)) u_bcd (
    .clk(clk), .rst_n(rst_n), .adv(tick), .digits(digits)
  );

  assign led        = timing_q;
  assign digit_ones = digits[3:0];
  assign digit_tens = digits[7:4];
  assign seg_ones   = digit_to_seg(digit_ones);
  assign seg_tens   = digit_to_seg(digit_tens);
endmodule

// File: rtl/rxn_timer_chk.sv
module rxn_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_pulse,
  input logic       btn_pressed,
  input logic       led,
  input logic [3:0] digit_ones,
  input logic [3:0] digit_tens
);
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |-> (!led && digit_ones == 4'd0 && digit_tens == 4'd0));

  assert_start_lights_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!led && start_pulse && !btn_pressed) |=> led);

  assert_digit_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (digit_ones <= 4'd9) && (digit_tens <= 4'd9));

  assert_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (digit_ones == 4'd9 && digit_tens != 4'd9) ##1 (digit_ones == 4'd0)
      |-> (digit_tens == $past(digit_tens) + 4'd1));

  assert_frozen_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !led |=> ($stable(digit_ones) && $stable(digit_tens)));

  assert_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (digit_ones == 4'd9 && digit_tens == 4'd9) |=> (digit_ones == 4'd9 && digit_tens == 4'd9));

  assert_press_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    btn_pressed |=> !led);
endmodule

bind rxn_timer rxn_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse), .btn_pressed(btn_pressed),
  .led(led), .digit_ones(digit_ones), .digit_tens(digit_tens)
);

// File: tb/rxn_timer_test.sv
module rxn_timer_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  PERIOD_CYC = 1024;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_pulse;
  logic       button_n;
  logic       led;
  logic [3:0] digit_ones, digit_tens;
  logic [6:0] seg_ones, seg_tens;

  int n_checks = 0;
  int n_fail   = 0;

  rxn_timer uut (
    .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse), .button_n(button_n),
    .led(led), .digit_ones(digit_ones), .digit_tens(digit_tens),
    .seg_ones(seg_ones), .seg_tens(seg_tens)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_count(input int m);
    int c = (m + 3) / PERIOD_CYC;
    return (c > 99) ? 99 : c;
  endfunction

  function automatic logic [6:0] exp_seg(input int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F; default: return 7'h00;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_count(input string req, input int c);
    check(req, digit_tens * 10 + digit_ones, c);
    check({req, " R10 seg ones"}, seg_ones, exp_seg(c % 10));
    check({req, " R10 seg tens"}, seg_tens, exp_seg(c / 10));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc(2);
    check("R1 led in reset", led, 0);
    check("R1 count in reset", digit_tens * 10 + digit_ones, 0);
    rst_n = 1'b1;
    cyc(1);
  endtask

  // start at the next edge, run m edges after it, then press
  task automatic run_case(input string tag, input int m, input bit mid_start);
    int got;
    start_pulse = 1'b1;
    cyc(1);
    start_pulse = 1'b0;
    check({tag, " R2 led after start"}, led, 1);
    if (mid_start && m > 10) begin
      cyc(m / 2);
      start_pulse = 1'b1;          // R8: ignored while timing
      cyc(1);
      start_pulse = 1'b0;
      cyc(m - m / 2 - 1);
    end else begin
      cyc(m);
    end
    check({tag, " R5 led before press"}, led, 1);
    button_n = 1'b0;
    cyc(2);
    check({tag, " R5 led two edges after sample"}, led, 1);
    cyc(1);
    check({tag, " R5 led off"}, led, 0);
    check_count({tag, " R3/R4 count"}, exp_count(m));
    got = digit_tens * 10 + digit_ones;
    cyc(PERIOD_CYC + 80);
    check({tag, " R6 frozen"}, digit_tens * 10 + digit_ones, got);
    button_n = 1'b1;
    cyc(4);
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed_dummy;
    rst_n = 1'b0;
    start_pulse = 1'b0;
    button_n = 1'b1;
    seed_dummy = $urandom(32'h1A2B);
    do_reset();

    // R3 boundary: step due exactly at the stop edge, and one cycle short
    run_case("R3 short", 1020, 1'b0);
    do_reset();
    run_case("R3 exact", 1021, 1'b0);
    do_reset();
    // R4 carry boundary at 9 and 10
    run_case("R4 nine", 10 * PERIOD_CYC - 4, 1'b0);
    do_reset();
    run_case("R4 ten", 10 * PERIOD_CYC - 3, 1'b1);
    do_reset();

    // R9: press held, start ignored
    button_n = 1'b0;
    cyc(3);
    start_pulse = 1'b1;
    cyc(1);
    start_pulse = 1'b0;
    check("R9 press wins over start", led, 0);
    button_n = 1'b1;
    cyc(4);

    // random lengths, some with a start pulse while timing (R8)
    for (int i = 0; i < 3; i++) begin
      int m = 40 + int'($urandom % 5000);
      run_case("R8 random", m, i[0] == 1'b0);
      do_reset();
    end

    // R7 saturation
    start_pulse = 1'b1;
    cyc(1);
    start_pulse = 1'b0;
    cyc(101 * PERIOD_CYC);
    check("R7 led still on", led, 1);
    check_count("R7 saturated", 99);
    cyc(PERIOD_CYC);
    check_count("R7 still 99", 99);

    // R1 asynchronous reset mid-run
    #(CLK_PERIOD/4) rst_n = 1'b0;
    #1;
    check("R1 async led", led, 0);
    check("R1 async count", digit_tens * 10 + digit_ones, 0);
    cyc(1);
    rst_n = 1'b1;
    cyc(2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule